// File: doc/BRIEF.md
# Receive and transmit ready-strobe generator with FIFO occupancy

This block produces the two active-low ready strobes that a 16550-style serial port offers to an external transfer engine. It keeps the receive and transmit FIFOs itself, so their occupancy is known exactly every cycle. The serial side deposits received characters and removes characters to send. The host side reads received characters and writes characters to send. The block turns the two fill levels into `rxrdy_n` and `txrdy_n`.

Two signalling modes exist. Mode 0 covers both the single-holding-register mode and the FIFO mode with the mode bit clear, and it gives a plain "something there / nothing there" indication. Mode 1 needs the FIFOs enabled and the mode bit set. In mode 1 both strobes are sticky: the receive strobe fires on a fill threshold or a timeout flag and releases only when the FIFO is empty, and the transmit strobe fires on empty and releases only when the FIFO is full. The receive timeout is computed elsewhere and arrives as an input.

Top module: `uart_ready_pins`

## Requirements
- R1: While `rst_n` is low, both counts are 0 and both `rxrdy_n` and `txrdy_n` are 1. At the first clock edge after reset is released, `txrdy_n` drops to 0 because the transmit side is empty.
- R2: Capacity is DEPTH (16) characters when `fifo_en`=1 and 1 character when `fifo_en`=0. A write that finds the store at or above capacity before the edge is dropped, and the count does not change.
- R3: Each side returns characters in the order they were written. `rx_rdata` and `tx_rdata` always show the oldest stored character. A read of an empty side is ignored.
- R4: Mode 0 applies when `fifo_en`=0 (whatever `mode_sel` is) or when `mode_sel`=0. In mode 0, `rxrdy_n` is 0 exactly when the receive count was non-zero at the previous edge.
- R5: In mode 1, `rxrdy_n` falls when the receive count reaches the trigger level. The trigger is selected by `rx_trig`: 00 gives 1, 01 gives 4, 10 gives 8, and 11 gives DEPTH-2 (14).
- R6: In mode 1, a high `rx_timeout` with a non-empty receive FIFO also makes `rxrdy_n` fall. Once low, `rxrdy_n` stays low until the receive count is 0, and empty takes priority over timeout.
- R7: In mode 0, `txrdy_n` is 0 exactly when the transmit count was 0 at the previous edge.
- R8: In mode 1, `txrdy_n` falls when the transmit count is 0 and rises only when the count equals DEPTH. At any fill in between, it holds its value.
- R9: `rx_clr` and `tx_clr` empty their side at the next edge, and a write in that same cycle is dropped. The ready strobe reflects the empty side one edge later.
- R10: Both strobes are registered. They respond to counts and to mode inputs one clock after the count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects 16-deep FIFOs, 0 selects single holding registers |
| mode_sel | input | 1 | Selects signalling mode 1 when FIFOs are enabled |
| rx_trig | input | 2 | Receive trigger select (1/4/8/14) |
| rx_timeout | input | 1 | Receive timeout flag from the timeout counter |
| rx_clr | input | 1 | Empty the receive side |
| tx_clr | input | 1 | Empty the transmit side |
| rx_wr | input | 1 | Serial side deposits a received character |
| rx_wdata | input | DW | Received character |
| rx_rd | input | 1 | Host reads the oldest received character |
| rx_rdata | output | DW | Oldest received character |
| tx_wr | input | 1 | Host writes a character to send |
| tx_wdata | input | DW | Character to send |
| tx_rd | input | 1 | Shifter takes the oldest character to send |
| tx_rdata | output | DW | Oldest character to send |
| rx_count | output | $clog2(DEPTH+1) | Receive occupancy |
| tx_count | output | $clog2(DEPTH+1) | Transmit occupancy |
| rxrdy_n | output | 1 | Active-low receive ready strobe |
| txrdy_n | output | 1 | Active-low transmit ready strobe |

## Verification
Directed runs walk the receive fill up to one below each of the four trigger levels and then across it. This separates a wrong threshold encoding from a wrong comparison. Further directed runs fill the transmit side to 15 and then 16 characters and drain it back, which shows the mode-1 hysteresis apart from the mode-0 tracking. Separate single-character and timeout-only cases show that empty takes priority and that timeout alone can fire the strobe. A long random phase then mixes writes, reads, clears, timeouts and mode changes on the fly. In that phase a reference model catches any ordering, capacity or hold-state error.

// File: rtl/uart_ready_pins.sv
module uart_ready_pins #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic                       mode_sel,
  input  logic [1:0]                 rx_trig,
  input  logic                       rx_timeout,
  input  logic                       rx_clr,
  input  logic                       tx_clr,
  input  logic                       rx_wr,
  input  logic [DW-1:0]              rx_wdata,
  input  logic                       rx_rd,
  output logic [DW-1:0]              rx_rdata,
  input  logic                       tx_wr,
  input  logic [DW-1:0]              tx_wdata,
  input  logic                       tx_rd,
  output logic [DW-1:0]              tx_rdata,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic                       rxrdy_n,
  output logic                       txrdy_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] rx_mem [DEPTH];
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0] rx_cnt, tx_cnt, trig;

  wire [CW-1:0] cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          m1    = fifo_en & mode_sel;
  wire          rx_in = rx_wr && (rx_cnt < cap) && !rx_clr;
  wire          rx_out = rx_rd && (rx_cnt != 0) && !rx_clr;
  wire          tx_in = tx_wr && (tx_cnt < cap) && !tx_clr;
  wire          tx_out = tx_rd && (tx_cnt != 0) && !tx_clr;

  always_comb begin
    case (rx_trig)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(DEPTH-2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rx_in) rx_mem[rx_wp] <= rx_wdata;
    if (tx_in) tx_mem[tx_wp] <= tx_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxrdy_n <= 1'b1;
      txrdy_n <= 1'b1;
    end else begin
      if (!m1)                                 rxrdy_n <= (rx_cnt == 0);
      else if (rx_cnt == 0)                    rxrdy_n <= 1'b1;
      else if (rx_cnt >= trig || rx_timeout)   rxrdy_n <= 1'b0;

      if (!m1)                    txrdy_n <= (tx_cnt != 0);
      else if (tx_cnt == 0)       txrdy_n <= 1'b0;
      else if (tx_cnt == CW'(DEPTH)) txrdy_n <= 1'b1;
    end
  end

  assign rx_rdata = rx_mem[rx_rp];
  assign tx_rdata = tx_mem[tx_rp];
  assign rx_count = rx_cnt;
  assign tx_count = tx_cnt;
endmodule

// File: rtl/uart_ready_pins_chk.sv
module uart_ready_pins_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          mode_sel,
  input logic          rx_clr,
  input logic          tx_clr,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rxrdy_n,
  input logic          txrdy_n
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  p_rx_mode0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_en && mode_sel) && rx_count != 0) |=> !rxrdy_n);

  p_rx_empty_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == 0) |=> rxrdy_n);

  p_tx_mode0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_en && mode_sel) && tx_count != 0) |=> txrdy_n);

  p_tx_full_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && mode_sel && tx_count == CW'(DEPTH)) |=> txrdy_n);

  p_tx_empty_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == 0) |=> !txrdy_n);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr |=> rx_count == 0) and (tx_clr |=> tx_count == 0));
endmodule

bind uart_ready_pins uart_ready_pins_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_sel(mode_sel),
  .rx_clr(rx_clr), .tx_clr(tx_clr), .rx_count(rx_count), .tx_count(tx_count),
  .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
);

// File: tb/uart_ready_pins_tb_top.sv
module uart_ready_pins_tb_top;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, mode_sel = 0, rx_timeout = 0, rx_clr = 0, tx_clr = 0;
  logic [1:0] rx_trig = 0;
  logic rx_wr = 0, rx_rd = 0, tx_wr = 0, tx_rd = 0;
  logic [7:0] rx_wdata = 0, tx_wdata = 0, rx_rdata, tx_rdata;
  logic [CW-1:0] rx_count, tx_count;
  logic rxrdy_n, txrdy_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] rxq[$], txq[$];
  logic m_rxn = 1, m_txn = 1;

  always #5 clk = ~clk;

  uart_ready_pins #(.DEPTH(DEPTH), .DW(8)) dut_i (.*);

  function automatic int trig_of(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return DEPTH-2; endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit rw, logic [7:0] rd_, bit rr, bit tw, logic [7:0] td, bit tr,
                      bit rc, bit tc, bit to);
    int rc0, tc0, cap, trg;
    bit m1, nrx, ntx;
    @(negedge clk);
    rx_wr = rw; rx_wdata = rd_; rx_rd = rr; tx_wr = tw; tx_wdata = td; tx_rd = tr;
    rx_clr = rc; tx_clr = tc; rx_timeout = to;
    rc0 = rxq.size(); tc0 = txq.size();
    cap = fifo_en ? DEPTH : 1; m1 = fifo_en && mode_sel; trg = trig_of(rx_trig);
    nrx = m_rxn; ntx = m_txn;
    if (!m1) nrx = (rc0 == 0); else if (rc0 == 0) nrx = 1; else if (rc0 >= trg || to) nrx = 0;
    if (!m1) ntx = (tc0 != 0); else if (tc0 == 0) ntx = 0; else if (tc0 == DEPTH) ntx = 1;
    @(posedge clk); #1;
    if (rc) rxq.delete();
    else begin
      if (rr && rc0 != 0) void'(rxq.pop_front());
      if (rw && rc0 < cap) rxq.push_back(rd_);
    end
    if (tc) txq.delete();
    else begin
      if (tr && tc0 != 0) void'(txq.pop_front());
      if (tw && tc0 < cap) txq.push_back(td);
    end
    m_rxn = nrx; m_txn = ntx;
    chk(tag, "rx_count", int'(rx_count), rxq.size());
    chk(tag, "tx_count", int'(tx_count), txq.size());
    chk(tag, "rxrdy_n", int'(rxrdy_n), int'(m_rxn));
    chk(tag, "txrdy_n", int'(txrdy_n), int'(m_txn));
    if (rxq.size() != 0) chk(tag, "rx_rdata", int'(rx_rdata), int'(rxq[0]));
    if (txq.size() != 0) chk(tag, "tx_rdata", int'(tx_rdata), int'(txq[0]));
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rxrdy_n in reset", int'(rxrdy_n), 1);
    chk("R1", "txrdy_n in reset", int'(txrdy_n), 1);
    chk("R1", "rx_count in reset", int'(rx_count), 0);
    @(negedge clk); rst_n = 1;
    idle("R1");
    chk("R1", "txrdy_n after reset", int'(txrdy_n), 0);

    // R4 mode 0 receive, FIFO enabled
    fifo_en = 1; mode_sel = 0;
    step("R4", 1, 8'hA1, 0, 0, 0, 0, 0, 0, 0);
    idle("R4");
    step("R4", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    idle("R4");
    // R4 mode bit ignored with FIFOs disabled; R2 holding register of one
    fifo_en = 0; mode_sel = 1;
    for (int i = 0; i < 3; i++) step("R2", 1, 8'(8'h30 + i), 0, 1, 8'(8'h50 + i), 0, 0, 0, 0);
    idle("R4");
    step("R7", 0, 0, 1, 0, 0, 1, 0, 0, 0);
    idle("R7");
    // R3 ordering in FIFO mode
    fifo_en = 1; mode_sel = 0;
    for (int i = 0; i < 5; i++) step("R3", 1, 8'(8'hC0 + i), 0, 1, 8'(8'h10 + i), 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R3", 0, 0, 1, 0, 0, 1, 0, 0, 0);
    idle("R7");
    // R2 overflow in FIFO mode
    for (int i = 0; i < DEPTH + 3; i++) step("R2", 1, 8'(i), 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle("R9");
    // R5 trigger levels in mode 1
    mode_sel = 1;
    for (int s = 0; s < 4; s++) begin
      rx_trig = 2'(s);
      for (int i = 0; i < trig_of(2'(s)) - 1; i++) step("R5", 1, 8'(s*16+i), 0, 0, 0, 0, 0, 0, 0);
      idle("R5");
      step("R5", 1, 8'hEE, 0, 0, 0, 0, 0, 0, 0);
      idle("R5"); idle("R5");
      while (rxq.size() > 1) step("R6", 0, 0, 1, 0, 0, 0, 0, 0, 0);
      idle("R6");
      step("R6", 0, 0, 1, 0, 0, 0, 0, 0, 0);
      idle("R6");
    end
    // R6 timeout fire, empty priority
    rx_trig = 2'd3;
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R6");
    step("R6", 1, 8'h77, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle("R6");
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle("R9");
    // R8 transmit hysteresis
    for (int i = 0; i < DEPTH - 1; i++) step("R8", 0, 0, 0, 1, 8'(i), 0, 0, 0, 0);
    idle("R8");
    step("R8", 0, 0, 0, 1, 8'hF0, 0, 0, 0, 0);
    idle("R8");
    for (int i = 0; i < DEPTH - 1; i++) step("R8", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle("R8");
    step("R8", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    idle("R8");
    step("R9", 0, 0, 0, 1, 8'h11, 0, 0, 1, 0);
    idle("R9");

    // R10 random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) fifo_en = ~fifo_en;
      else if (r < 6) mode_sel = ~mode_sel;
      else if (r < 9) rx_trig = 2'($urandom_range(0, 3));
      step("R10", $urandom_range(0, 9) < 5, 8'($urandom), $urandom_range(0, 9) < 4,
           $urandom_range(0, 9) < 5, 8'($urandom), $urandom_range(0, 9) < 4,
           $urandom_range(0, 99) < 2, $urandom_range(0, 99) < 2, $urandom_range(0, 19) == 0);
    end
    finish_run();
  end
endmodule